// File: doc/BRIEF.md
# Two-Phase Retention Clock Controller

This block turns a fast system clock into a pair of non-overlapping shift phases, `phi1` and `phi2`, for a chain of master/slave storage stages. It also drives a complementary pair of feedback controls: `fb` closes a keeper loop inside every latch, and `fbb` opens the forward pass path. A normal shift pair is a gap with both phases low, then `phi1` high, another gap, then `phi2` high. The lengths of the phase and the gap are set at run time, in system-clock cycles.

A hold request parks the chain without losing its contents, and the hold can take one of two forms. In static hold, both phases stay high together for as long as the request is held. In refresh hold, both phases stay low most of the time and pulse high together for a short programmed window. They pulse again after each programmed interval, so that stored levels are restored. When the request is released, shifting resumes at the start of a pair, so the data sequence continues without loss or repetition.

A 4-stage recirculating shift model is driven from the generated phases, with a side entry used to load a word. It lets state retention be observed at the ports.

Top module: `twophase_retain_ctrl`

## Requirements
- R1: While `fb` is low, `phi1` and `phi2` are never high in the same cycle.
- R2: A shift pair is `gap_len` cycles with both phases low, `phase_len` cycles of `phi1` alone, `gap_len` cycles low, then `phase_len` cycles of `phi2` alone. A length of 0 is treated as 1.
- R3: Each completed shift pair moves the model by one place: `q[i]` takes the old `q[i-1]`, and `q[0]` takes `load_bit` when `load_en` is 1, otherwise the old `q[3]`. The input is captured while `phi1` is high, and `q` changes only while `phi2` is high.
- R4: `hold_req` is acted on only at the end of a `phi2` phase. The pair in progress always finishes with a solo `phi2`.
- R5: `fbb` is always the inverse of `fb`. `fb` rises in a cycle where both phases are low, exactly one cycle before the phases rise together. It falls only after both phases have been low for at least one cycle.
- R6: In static hold (`refresh_sel` = 0 when the hold begins), both phases are high in every cycle after the `fb` lead cycle until release.
- R7: In refresh hold (`refresh_sel` = 1), both phases pulse high together for `pulse_len` cycles, starting the cycle after `fb` rises. Consecutive pulses are separated by `interval_len` cycles with both phases low.
- R8: In refresh hold, an `interval_len` of 0 keeps both phases high continuously, as in static hold.
- R9: While `fbb` is low, `q` does not change, and `load_en`/`load_bit` have no effect.
- R10: On release, both phases go low, then `fb` falls. After `gap_len` cycles `phi1` rises alone, and the rotation carries on from the next position.
- R11: During reset the phases are low, `fb` = 0, `fbb` = 1 and `q` = 0. The first activity after reset is a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_req | input | 1 | Request to park the chain in a hold mode |
| refresh_sel | input | 1 | 1 selects refresh hold, 0 selects static hold |
| load_en | input | 1 | Model input takes `load_bit` instead of recirculating |
| load_bit | input | 1 | Bit to enter the first model stage |
| phase_len | input | 16 | High time of each phase, in cycles |
| gap_len | input | 16 | Non-overlap gap, in cycles |
| pulse_len | input | 16 | Refresh pulse width, in cycles |
| interval_len | input | 16 | Low time between refresh pulses, in cycles |
| phi1 | output | 1 | First shift phase |
| phi2 | output | 1 | Second shift phase |
| fb | output | 1 | Keeper-loop enable |
| fbb | output | 1 | Forward-path enable, inverse of `fb` |
| q | output | 4 | Outputs of the model stages |

## Verification
The assertions on phase overlap and on the ordering of `fb` make no assumption about the inputs: they must hold for any sequence of `hold_req`, `refresh_sel` and length values. The check on retention assumes only that the model is written solely through the forward path. The scoreboard does assume that `load_en`/`load_bit` stay constant while `phi1` is high, and that the length inputs change only during a gap. The stimulus meets this by changing them a few nanoseconds after a `phi2` falls, which is always inside the following gap of at least one cycle.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [3:0] {
    ST_GAP_A,   // low gap ahead of phi1
    ST_PH1,     // phi1 alone
    ST_GAP_B,   // low gap ahead of phi2
    ST_PH2,     // phi2 alone
    ST_FB_ON,   // keeper enabled, phases low
    ST_HOLD,    // both phases high, static
    ST_RPULSE,  // both phases high, refresh pulse
    ST_RWAIT,   // both phases low, refresh wait
    ST_FB_OFF   // phases low, keeper still on
  } rc_state_e;

  function automatic logic is_shift_state(input rc_state_e s);
    return (s == ST_GAP_A) || (s == ST_PH1) || (s == ST_GAP_B) || (s == ST_PH2);
  endfunction
endpackage

// File: rtl/rc_seq.sv
module rc_seq
  import rc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_req,
  input  logic          refresh_sel,
  input  logic [CW-1:0] phase_len,
  input  logic [CW-1:0] gap_len,
  input  logic [CW-1:0] pulse_len,
  input  logic [CW-1:0] interval_len,
  output rc_state_e     state_d
);
  localparam logic [CW-1:0] ONE = CW'(1);

  rc_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] span_m1;
  logic          span_end;
  logic          ivl_zero;

  function automatic logic [CW-1:0] len_m1(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  always_comb begin
    case (state_q)
      ST_GAP_A, ST_GAP_B: span_m1 = len_m1(gap_len);
      ST_PH1, ST_PH2:     span_m1 = len_m1(phase_len);
      ST_RPULSE:          span_m1 = len_m1(pulse_len);
      ST_RWAIT:           span_m1 = len_m1(interval_len);
      default:            span_m1 = '0;
    endcase
  end

  // ">=" keeps a shortened length from stalling the count
  assign span_end = (cnt_q >= span_m1);
  assign ivl_zero = (interval_len == '0);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_GAP_A:  if (span_end) state_d = ST_PH1;
      ST_PH1:    if (span_end) state_d = ST_GAP_B;
      ST_GAP_B:  if (span_end) state_d = ST_PH2;
      ST_PH2:    if (span_end) state_d = hold_req ? ST_FB_ON : ST_GAP_A;
      ST_FB_ON:  state_d = refresh_sel ? ST_RPULSE : ST_HOLD;
      ST_HOLD:   if (!hold_req) state_d = ST_FB_OFF;
      ST_RPULSE: begin
        if (!hold_req)     state_d = ST_FB_OFF;
        else if (span_end) state_d = ivl_zero ? ST_RPULSE : ST_RWAIT;
      end
      ST_RWAIT: begin
        if (!hold_req)     state_d = ST_FB_OFF;
        else if (span_end) state_d = ST_RPULSE;
      end
      ST_FB_OFF: state_d = ST_GAP_A;
      default:   state_d = ST_GAP_A;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GAP_A;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if ((state_d != state_q) || span_end) cnt_q <= '0;
      else                                  cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/rc_decode.sv
module rc_decode
  import rc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rc_state_e state_d,
  output logic      phi1,
  output logic      phi2,
  output logic      fb,
  output logic      fbb
);
  logic both_hi;
  assign both_hi = (state_d == ST_HOLD) || (state_d == ST_RPULSE);

  // registered from the next state so the outputs come straight off flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi1 <= 1'b0;
      phi2 <= 1'b0;
      fb   <= 1'b0;
      fbb  <= 1'b1;
    end else begin
      phi1 <= (state_d == ST_PH1) || both_hi;
      phi2 <= (state_d == ST_PH2) || both_hi;
      fb   <= !is_shift_state(state_d);
      fbb  <= is_shift_state(state_d);
    end
  end
endmodule

// File: rtl/rc_stage.sv
module rc_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic phi1,
  input  logic phi2,
  input  logic fbb,
  input  logic d,
  output logic q
);
  logic mst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst <= 1'b0;
      q   <= 1'b0;
    end else begin
      if (phi1 && fbb) mst <= d;
      if (phi2 && fbb) q   <= mst;
    end
  end
endmodule

// File: rtl/twophase_retain_ctrl.sv
module twophase_retain_ctrl #(
  parameter int CW     = 16,
  parameter int NSTAGE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_req,
  input  logic              refresh_sel,
  input  logic              load_en,
  input  logic              load_bit,
  input  logic [CW-1:0]     phase_len,
  input  logic [CW-1:0]     gap_len,
  input  logic [CW-1:0]     pulse_len,
  input  logic [CW-1:0]     interval_len,
  output logic              phi1,
  output logic              phi2,
  output logic              fb,
  output logic              fbb,
  output logic [NSTAGE-1:0] q
);
  localparam int LAST = NSTAGE - 1;

  rc_pkg::rc_state_e state_d;
  logic [NSTAGE-1:0] stage_in;

  rc_seq #(.CW(CW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_req     (hold_req),
    .refresh_sel  (refresh_sel),
    .phase_len    (phase_len),
    .gap_len      (gap_len),
    .pulse_len    (pulse_len),
    .interval_len (interval_len),
    .state_d      (state_d)
  );

  rc_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .phi1    (phi1),
    .phi2    (phi2),
    .fb      (fb),
    .fbb     (fbb)
  );

  assign stage_in[0] = load_en ? load_bit : q[LAST];

  for (genvar i = 0; i < NSTAGE; i++) begin : g_chain
    if (i > 0) begin : g_link
      assign stage_in[i] = q[i-1];
    end
    rc_stage u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .phi1  (phi1),
      .phi2  (phi2),
      .fbb   (fbb),
      .d     (stage_in[i]),
      .q     (q[i])
    );
  end
endmodule

// File: rtl/rc_check.sv
module rc_check #(
  parameter int NSTAGE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phi1,
  input logic              phi2,
  input logic              fb,
  input logic              fbb,
  input logic [NSTAGE-1:0] q
);
  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fb |-> !(phi1 && phi2));

  p_fb_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fb != fbb);

  p_fb_leads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phi1 && phi2) |-> $past(fb));

  p_fb_rise_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb) |-> (!phi1 && !phi2));

  p_fb_trails_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fb) |-> (!phi1 && !phi2 && $past(!phi1 && !phi2)));

  p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!fbb) |-> $stable(q));
endmodule

bind twophase_retain_ctrl rc_check #(.NSTAGE(NSTAGE)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .phi1  (phi1),
  .phi2  (phi2),
  .fb    (fb),
  .fbb   (fbb),
  .q     (q)
);

// File: tb/twophase_retain_ctrl_tb.sv
module twophase_retain_ctrl_tb;
  localparam int CW = 16;
  localparam int NS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, hold_req, refresh_sel, load_en, load_bit;
  logic [CW-1:0] phase_len, gap_len, pulse_len, interval_len;
  logic phi1, phi2, fb, fbb;
  logic [NS-1:0] q;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic done = 1'b0;
  logic solo = 1'b0;
  logic [NS-1:0] ref_q = '0;
  logic [NS-1:0] exp_q[$];

  twophase_retain_ctrl #(.CW(CW), .NSTAGE(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .refresh_sel(refresh_sel),
    .load_en(load_en), .load_bit(load_bit), .phase_len(phase_len),
    .gap_len(gap_len), .pulse_len(pulse_len), .interval_len(interval_len),
    .phi1(phi1), .phi2(phi2), .fb(fb), .fbb(fbb), .q(q)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // monitor: a phi2 that rose without phi1 ends a real shift pair
  always @(posedge phi2) begin
    #2;
    solo = !phi1;
  end

  always @(negedge phi2) begin
    #2;
    if (solo && exp_q.size() > 0) begin
      logic [NS-1:0] e;
      e = exp_q.pop_front();
      chk(q == e, "R3 rotation", q, e);
    end
  end

  // driver: after a pair ends, set the input for the next pair and predict it
  task automatic step(input logic use_load, input logic b);
    logic d0;
    do @(negedge phi2); while (!solo);
    #3;
    load_en  = use_load;
    load_bit = b;
    d0 = use_load ? b : ref_q[NS-1];
    ref_q = {ref_q[NS-2:0], d0};
    exp_q.push_back(ref_q);
  endtask

  task automatic push_recirc();
    ref_q = {ref_q[NS-2:0], ref_q[NS-1]};
    exp_q.push_back(ref_q);
  endtask

  task automatic run_len(input logic want1, input logic lvl, output int n);
    n = 0;
    while ((want1 ? phi1 : phi2) == lvl) begin
      n++;
      @(posedge clk);
      #2;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 30000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [NS-1:0] held;
    logic ok;
    rst_n = 1'b0; hold_req = 1'b0; refresh_sel = 1'b0;
    load_en = 1'b0; load_bit = 1'b0;
    phase_len = 16'd3; gap_len = 16'd2; pulse_len = 16'd2; interval_len = 16'd20;

    repeat (3) @(posedge clk);
    #2;
    chk(!phi1 && !phi2, "R11 phases low", {phi1, phi2}, 0);
    chk(!fb && fbb, "R11 fb/fbb", {fb, fbb}, 1);
    chk(q == '0, "R11 q clear", q, 0);
    @(negedge clk) rst_n = 1'b1;

    // R2 pair shape
    @(posedge phi1); #2;
    chk(!phi2, "R1 phi2 low with phi1", phi2, 0);
    run_len(1'b1, 1'b1, n); chk(n == 3, "R2 phi1 width", n, 3);
    run_len(1'b0, 1'b0, n); chk(n == 2, "R2 gap before phi2", n, 2);
    chk(!phi1, "R1 phi1 low with phi2", phi1, 0);
    run_len(1'b0, 1'b1, n); chk(n == 3, "R2 phi2 width", n, 3);

    // R3 load 0101, then recirculate
    step(1'b1, 1'b0); step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    chk(fbb == !fb, "R5 complementary", fbb, !fb);

    // static hold
    step(1'b0, 1'b0);
    hold_req = 1'b1; refresh_sel = 1'b0;
    @(posedge phi2); #2;
    chk(!phi1 && !fb, "R4 pair finishes", {phi1, fb}, 0);
    @(posedge fb); #2;
    chk(!phi1 && !phi2, "R5 fb leads phases", {phi1, phi2}, 0);
    chk(!fbb, "R5 fbb low in hold", fbb, 0);
    @(posedge clk); #2;
    chk(phi1 && phi2, "R6 both high", {phi1, phi2}, 3);
    held = q;
    load_en = 1'b1; load_bit = ~held[0];
    ok = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(posedge clk); #2;
      if (!(phi1 && phi2 && fb)) ok = 1'b0;
    end
    chk(ok, "R6 held high throughout", ok, 1);
    chk(q == held, "R9 static retention", q, held);
    load_en = 1'b0;
    push_recirc();
    hold_req = 1'b0;
    @(negedge fb); #2;
    chk(!phi1 && !phi2, "R10 phases low at fb fall", {phi1, phi2}, 0);
    n = 0;
    while (!phi1) begin @(posedge clk); #2; n++; end
    chk(n == 2, "R10 gap before phi1", n, 2);
    chk(!phi2, "R10 phi1 first", phi2, 0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

    // refresh hold
    step(1'b0, 1'b0);
    hold_req = 1'b1; refresh_sel = 1'b1;
    @(posedge fb); #2;
    held = q;
    @(posedge clk); #2;
    chk(phi1 && phi2, "R7 pulse follows fb", {phi1, phi2}, 3);
    run_len(1'b1, 1'b1, n); chk(n == 2, "R7 pulse width", n, 2);
    run_len(1'b1, 1'b0, n); chk(n == 20, "R7 interval", n, 20);
    chk(phi2, "R7 phases pulse together", phi2, 1);
    chk(q == held, "R9 refresh retention", q, held);
    push_recirc();
    hold_req = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

    // zero interval
    interval_len = 16'd0;
    step(1'b0, 1'b0);
    hold_req = 1'b1; refresh_sel = 1'b1;
    @(posedge fb);
    @(posedge clk); #2;
    ok = 1'b1;
    for (int i = 0; i < 30; i++) begin
      if (!(phi1 && phi2)) ok = 1'b0;
      @(posedge clk); #2;
    end
    chk(ok, "R8 zero interval continuous", ok, 1);
    push_recirc();
    hold_req = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    interval_len = 16'd20;

    // zero lengths act as one
    step(1'b0, 1'b0);
    phase_len = 16'd0; gap_len = 16'd0;
    @(posedge phi1); #2;
    run_len(1'b1, 1'b1, n); chk(n == 1, "R2 zero phase_len", n, 1);
    run_len(1'b0, 1'b0, n); chk(n == 1, "R2 zero gap_len", n, 1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

    repeat (40) @(posedge clk);
    chk(exp_q.size() == 0, "R3 all pairs seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule